// File: doc/BRIEF.md
# SDR SDRAM Controller with Periodic Refresh

This block sits between a simple single-word request port and a four-bank, 16-bit single-data-rate SDRAM with 12 row bits and 8 column bits. After reset it runs the power-up sequence. It waits a programmable settling time, precharges every bank, issues two auto refreshes and then loads the mode register. Only after that does it accept user requests.

Each accepted request is a read or a write of one 16-bit word with a byte mask. It becomes an ACTIVE command, then a READ or WRITE with auto precharge set. Between commands the block inserts NOPs to meet the row-to-column delay, the precharge time and the refresh cycle time. Because every access closes its row, all banks are idle whenever the controller is waiting. A down-counter raises a refresh request at the rate needed for 4096 refreshes per window. That request is served before any waiting user request once the access in flight has completed. Read data is captured a programmed CAS latency (2 or 3) after the READ and returned with a one-cycle strobe.

Top module: `sdram_ctrl`

## Requirements
- R1: The command pins (sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n) use these encodings: NOP 0111, ACTIVE 0011, READ 0101, WRITE 0100, PRECHARGE 0010, AUTO REFRESH 0001, LOAD MODE 0000. While rst is high, the pins show NOP and req_ready and rd_valid are low.
- R2: The first four non-NOP commands after reset are, in order:
  - PRECHARGE with sd_addr[10] high (all banks);
  - AUTO REFRESH;
  - AUTO REFRESH;
  - LOAD MODE with sd_addr = CAS latency in bits 6:4 and zeros elsewhere (burst length 1, sequential order).
- R3: No command other than NOP appears during the first INIT_CYCLES cycles after reset, and req_ready stays low until the mode load has been issued.
- R4: A request address splits as bank = req_addr[21:20], row = req_addr[19:8], column = req_addr[7:0]. ACTIVE drives the bank on sd_ba and the row on sd_addr, and the access that follows drives the column on sd_addr[7:0] for the same bank.
- R5: READ and WRITE always carry sd_addr[10] high (auto precharge). They are presented no earlier than TRCD cycles after the ACTIVE of their bank, and the cycle after an ACTIVE carries NOP.
- R6: The next command waits before it is presented:
  - after a READ: at least CAS_LAT+TRP cycles;
  - after a WRITE: at least TWR+TRP cycles;
  - after an AUTO REFRESH: at least TRC cycles;
  - after a precharge of all banks: at least TRP cycles.
- R7: For a read, rd_valid is high for exactly one cycle, CAS_LAT+1 cycles after the cycle in which READ is presented. rd_data holds sd_dq_in as sampled CAS_LAT clock edges after the edge that registers the READ.
- R8: A WRITE presents req_wdata on sd_dq_out with sd_dq_oe high and sd_dqm equal to req_mask. sd_dqm bit 0 covers bits 7:0 and bit 1 covers bits 15:8, and a mask bit of 1 leaves that byte unwritten. A READ presents sd_dqm = 00.
- R9: AUTO REFRESH is issued only when no bank has an open row. Refreshes recur every CLK_KHZ*W/4096 cycles, where W is 64 (ms), or 16 when HIGH_TEMP is 1. The spacing between refreshes grows by at most the length of one access.
- R10: Once a refresh is due, req_ready goes low and the refresh is issued before any further ACTIVE, even under a continuous stream of requests. While req_ready is high, the command pins show NOP.
- R11: rd_valid is never raised except as the return of a READ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising-edge active |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | User request present |
| req_ready | output | 1 | Request accepted on a cycle where both are high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | Word address {bank, row, column} |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Byte mask, 1 = byte not written |
| rd_valid | output | 1 | One-cycle strobe with read data |
| rd_data | output | 16 | Returned read word |
| sd_cs_n | output | 1 | SDRAM chip select, low active |
| sd_ras_n | output | 1 | SDRAM row strobe |
| sd_cas_n | output | 1 | SDRAM column strobe |
| sd_we_n | output | 1 | SDRAM write enable |
| sd_ba | output | 2 | SDRAM bank address |
| sd_addr | output | 12 | SDRAM address / op-code |
| sd_dqm | output | 2 | SDRAM byte masks |
| sd_dq_out | output | 16 | Write data toward the pads |
| sd_dq_oe | output | 1 | Output enable for the data pads |
| sd_dq_in | input | 16 | Read data from the pads |

## Verification
The bench builds the controller with CLK_KHZ = 2048, so the refresh period shrinks to 32 cycles. It also sets INIT_CYCLES = 20, CAS_LAT = 3, TRCD = 3, TRP = 2, TRC = 4 and TWR = 2. The short refresh period puts a dozen refreshes inside a few hundred cycles, so refresh contends with a back-to-back request stream and the priority rule is exercised. The short settling time lets the whole power-up order be checked early in the run. The three-cycle latency exercises the full depth of the capture pipeline, against a memory model that drives data only in the one cycle it is due.

// File: rtl/sdram_ctrl_pkg.sv
package sdram_ctrl_pkg;

    localparam int unsigned BANK_W = 2;
    localparam int unsigned ROW_W  = 12;
    localparam int unsigned COL_W  = 8;
    localparam int unsigned DATA_W = 16;
    localparam int unsigned MASK_W = DATA_W / 8;
    localparam int unsigned ADDR_W = BANK_W + ROW_W + COL_W;
    localparam int unsigned AP_BIT = 10;
    localparam int unsigned REFRESHES_PER_WINDOW = 4096;

    // {cs_n, ras_n, cas_n, we_n}
    typedef logic [3:0] sd_cmd_t;
    localparam sd_cmd_t CMD_NOP     = 4'b0111;
    localparam sd_cmd_t CMD_ACTIVE  = 4'b0011;
    localparam sd_cmd_t CMD_READ    = 4'b0101;
    localparam sd_cmd_t CMD_WRITE   = 4'b0100;
    localparam sd_cmd_t CMD_PRECHG  = 4'b0010;
    localparam sd_cmd_t CMD_REFRESH = 4'b0001;
    localparam sd_cmd_t CMD_LOADMR  = 4'b0000;

    typedef enum logic [3:0] {
        ST_POWERUP,
        ST_PRE_ALL,
        ST_REF_A,
        ST_REF_B,
        ST_LOAD_MODE,
        ST_IDLE,
        ST_ACTIVATE,
        ST_ACCESS,
        ST_REFRESH,
        ST_HOLD
    } seq_state_t;

    typedef struct packed {
        logic              write;
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic [DATA_W-1:0] data;
        logic [MASK_W-1:0] mask;
    } user_req_t;

    function automatic user_req_t make_req(
        input logic              wr,
        input logic [ADDR_W-1:0] addr,
        input logic [DATA_W-1:0] data,
        input logic [MASK_W-1:0] mask
    );
        user_req_t r;
        r.write = wr;
        r.bank  = addr[ADDR_W-1 -: BANK_W];
        r.row   = addr[COL_W +: ROW_W];
        r.col   = addr[COL_W-1:0];
        r.data  = data;
        r.mask  = mask;
        return r;
    endfunction

    // burst length 1 (bits 2:0 = 0), sequential (bit 3 = 0), latency in 6:4
    function automatic logic [ROW_W-1:0] mode_word(input int unsigned cas_lat);
        logic [ROW_W-1:0] m;
        m      = '0;
        m[6:4] = 3'(cas_lat);
        return m;
    endfunction

endpackage

// File: rtl/sdram_refresh_timer.sv
module sdram_refresh_timer #(
    parameter int unsigned PERIOD = 781
) (
    input  logic clk,
    input  logic rst,
    input  logic ack,
    output logic due
);
    localparam int unsigned CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;

    logic [CW-1:0] remaining;

    always_ff @(posedge clk) begin
        if (rst) begin
            remaining <= CW'(PERIOD - 1);
            due       <= 1'b0;
        end else begin
            if (ack) begin
                due <= 1'b0;
            end
            if (remaining == '0) begin
                remaining <= CW'(PERIOD - 1);
                due       <= 1'b1;
            end else begin
                remaining <= remaining - 1'b1;
            end
        end
    end
endmodule

// File: rtl/sdram_read_capture.sv
module sdram_read_capture
    import sdram_ctrl_pkg::*;
#(
    parameter int unsigned CAS_LAT = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              read_issued,
    input  logic [DATA_W-1:0] dq_in,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    logic [CAS_LAT-1:0] in_flight;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_flight <= '0;
            rd_valid  <= 1'b0;
            rd_data   <= '0;
        end else begin
            in_flight <= {in_flight[CAS_LAT-2:0], read_issued};
            rd_valid  <= in_flight[CAS_LAT-1];
            if (in_flight[CAS_LAT-1]) begin
                rd_data <= dq_in;
            end
        end
    end
endmodule

// File: rtl/sdram_sequencer.sv
module sdram_sequencer
    import sdram_ctrl_pkg::*;
#(
    parameter int unsigned INIT_CYCLES = 10000,
    parameter int unsigned TRCD        = 2,
    parameter int unsigned TRP         = 2,
    parameter int unsigned TRC         = 4,
    parameter int unsigned TWR         = 2,
    parameter int unsigned CAS_LAT     = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [MASK_W-1:0] req_mask,
    input  logic              ref_due,
    output logic              req_ready,
    output logic              ref_ack,
    output sd_cmd_t           cmd,
    output logic [BANK_W-1:0] ba,
    output logic [ROW_W-1:0]  a,
    output logic [MASK_W-1:0] dqm,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    output logic              read_issued
);
    localparam int unsigned TMRD     = 2;
    localparam int unsigned RD_SPACE = CAS_LAT + TRP;
    localparam int unsigned WR_SPACE = TWR + TRP;
    localparam int unsigned MAX_WAIT = INIT_CYCLES + RD_SPACE + WR_SPACE + TRC + TRCD;
    localparam int unsigned CNT_W    = $clog2(MAX_WAIT + 1);

    seq_state_t       state, after;
    logic [CNT_W-1:0] cnt;
    user_req_t        cur;

    // a spacing of n cycles between two commands: issue cycle + n-1 waits
    function automatic logic [CNT_W-1:0] gap(input int unsigned n);
        return CNT_W'(n - 2);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_POWERUP;
            after <= ST_IDLE;
            cnt   <= CNT_W'(INIT_CYCLES - 1);
            cur   <= '0;
        end else begin
            case (state)
                ST_POWERUP: begin
                    if (cnt == '0) state <= ST_PRE_ALL;
                    else           cnt   <= cnt - 1'b1;
                end
                ST_PRE_ALL: begin
                    state <= ST_HOLD; cnt <= gap(TRP);  after <= ST_REF_A;
                end
                ST_REF_A: begin
                    state <= ST_HOLD; cnt <= gap(TRC);  after <= ST_REF_B;
                end
                ST_REF_B: begin
                    state <= ST_HOLD; cnt <= gap(TRC);  after <= ST_LOAD_MODE;
                end
                ST_LOAD_MODE: begin
                    state <= ST_HOLD; cnt <= gap(TMRD); after <= ST_IDLE;
                end
                ST_IDLE: begin
                    if (ref_due) begin
                        state <= ST_REFRESH;
                    end else if (req_valid) begin
                        cur   <= make_req(req_write, req_addr, req_wdata, req_mask);
                        state <= ST_ACTIVATE;
                    end
                end
                ST_ACTIVATE: begin
                    state <= ST_HOLD; cnt <= gap(TRCD); after <= ST_ACCESS;
                end
                ST_ACCESS: begin
                    state <= ST_HOLD;
                    cnt   <= cur.write ? gap(WR_SPACE) : gap(RD_SPACE);
                    after <= ST_IDLE;
                end
                ST_REFRESH: begin
                    state <= ST_HOLD; cnt <= gap(TRC);  after <= ST_IDLE;
                end
                ST_HOLD: begin
                    if (cnt == '0) state <= after;
                    else           cnt   <= cnt - 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        cmd         = CMD_NOP;
        ba          = '0;
        a           = '0;
        dqm         = '1;
        dq_out      = cur.data;
        dq_oe       = 1'b0;
        read_issued = 1'b0;
        ref_ack     = 1'b0;
        case (state)
            ST_PRE_ALL: begin
                cmd       = CMD_PRECHG;
                a[AP_BIT] = 1'b1;
            end
            ST_REF_A, ST_REF_B: cmd = CMD_REFRESH;
            ST_REFRESH: begin
                cmd     = CMD_REFRESH;
                ref_ack = 1'b1;
            end
            ST_LOAD_MODE: begin
                cmd = CMD_LOADMR;
                a   = mode_word(CAS_LAT);
            end
            ST_ACTIVATE: begin
                cmd = CMD_ACTIVE;
                ba  = cur.bank;
                a   = cur.row;
            end
            ST_ACCESS: begin
                cmd              = cur.write ? CMD_WRITE : CMD_READ;
                ba               = cur.bank;
                a[COL_W-1:0]     = cur.col;
                a[AP_BIT]        = 1'b1;
                dqm              = cur.write ? cur.mask : '0;
                dq_oe            = cur.write;
                read_issued      = !cur.write;
            end
            default: ;
        endcase
    end

    assign req_ready = (state == ST_IDLE) && !ref_due;

endmodule

// File: rtl/sdram_ctrl.sv
module sdram_ctrl
    import sdram_ctrl_pkg::*;
#(
    parameter int unsigned CLK_KHZ     = 50000,
    parameter bit          HIGH_TEMP   = 1'b0,
    parameter int unsigned INIT_CYCLES = 10000,
    parameter int unsigned TRCD        = 2,
    parameter int unsigned TRP         = 2,
    parameter int unsigned TRC         = 4,
    parameter int unsigned TWR         = 2,
    parameter int unsigned CAS_LAT     = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic                  req_write,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [DATA_W-1:0]     req_wdata,
    input  logic [MASK_W-1:0]     req_mask,
    output logic                  rd_valid,
    output logic [DATA_W-1:0]     rd_data,
    output logic                  sd_cs_n,
    output logic                  sd_ras_n,
    output logic                  sd_cas_n,
    output logic                  sd_we_n,
    output logic [BANK_W-1:0]     sd_ba,
    output logic [ROW_W-1:0]      sd_addr,
    output logic [MASK_W-1:0]     sd_dqm,
    output logic [DATA_W-1:0]     sd_dq_out,
    output logic                  sd_dq_oe,
    input  logic [DATA_W-1:0]     sd_dq_in
);
    localparam int unsigned WINDOW_MS  = HIGH_TEMP ? 16 : 64;
    localparam int unsigned REF_PERIOD = CLK_KHZ * WINDOW_MS / REFRESHES_PER_WINDOW;

    logic    ref_due, ref_ack, read_issued;
    sd_cmd_t cmd;

    sdram_refresh_timer #(.PERIOD(REF_PERIOD)) u_refresh (
        .clk (clk),
        .rst (rst),
        .ack (ref_ack),
        .due (ref_due)
    );

    sdram_sequencer #(
        .INIT_CYCLES (INIT_CYCLES),
        .TRCD        (TRCD),
        .TRP         (TRP),
        .TRC         (TRC),
        .TWR         (TWR),
        .CAS_LAT     (CAS_LAT)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .req_mask    (req_mask),
        .ref_due     (ref_due),
        .req_ready   (req_ready),
        .ref_ack     (ref_ack),
        .cmd         (cmd),
        .ba          (sd_ba),
        .a           (sd_addr),
        .dqm         (sd_dqm),
        .dq_out      (sd_dq_out),
        .dq_oe       (sd_dq_oe),
        .read_issued (read_issued)
    );

    sdram_read_capture #(.CAS_LAT(CAS_LAT)) u_capture (
        .clk         (clk),
        .rst         (rst),
        .read_issued (read_issued),
        .dq_in       (sd_dq_in),
        .rd_valid    (rd_valid),
        .rd_data     (rd_data)
    );

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;

endmodule

// File: rtl/sdram_ctrl_checker.sv
module sdram_ctrl_checker
    import sdram_ctrl_pkg::*;
#(
    parameter int unsigned CAS_LAT = 2
) (
    input logic clk,
    input logic rst,
    input logic cs_n,
    input logic ras_n,
    input logic cas_n,
    input logic we_n,
    input logic ap_bit,
    input logic req_ready,
    input logic rd_valid
);
    sd_cmd_t cmd;
    assign cmd = {cs_n, ras_n, cas_n, we_n};

    // R5: every column access closes its row
    a_r5_access_autoprecharge: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_READ || cmd == CMD_WRITE) |-> ap_bit);

    // R5: the row-to-column delay always leaves at least one NOP after ACTIVE
    a_r5_nop_after_active: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_ACTIVE) |=> (cmd == CMD_NOP));

    // R11: a read strobe is the return of a READ issued CAS_LAT+1 cycles before
    a_r11_strobe_after_read: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(cmd == CMD_READ, CAS_LAT + 1));

    // R7: the read strobe lasts a single cycle
    a_r7_single_strobe: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);

    // R10: the controller is quiet whenever it offers to take a request
    a_r10_ready_when_quiet: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (cmd == CMD_NOP));

    // R9: a refresh is preceded by a quiet cycle
    a_r9_refresh_after_nop: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_REFRESH) |-> ($past(cmd) == CMD_NOP));

endmodule

bind sdram_ctrl sdram_ctrl_checker #(.CAS_LAT(CAS_LAT)) u_checker (
    .clk       (clk),
    .rst       (rst),
    .cs_n      (sd_cs_n),
    .ras_n     (sd_ras_n),
    .cas_n     (sd_cas_n),
    .we_n      (sd_we_n),
    .ap_bit    (sd_addr[10]),
    .req_ready (req_ready),
    .rd_valid  (rd_valid)
);

// File: tb/sdram_ctrl_bench.sv
`timescale 1ns/1ps
module sdram_ctrl_bench;

    localparam int CLK_KHZ = 2048;
    localparam int INIT    = 20;
    localparam int CL      = 3;
    localparam int TRCD    = 3;
    localparam int TRP     = 2;
    localparam int TRC     = 4;
    localparam int TWR     = 2;
    localparam int REF_PER = CLK_KHZ * 64 / 4096;

    localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD = 4'b0101,
                           C_WR = 4'b0100, C_PRE = 4'b0010, C_REF = 4'b0001,
                           C_LMR = 4'b0000;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_ready, req_write;
    logic [21:0] req_addr;
    logic [15:0] req_wdata;
    logic [1:0]  req_mask;
    logic        rd_valid;
    logic [15:0] rd_data;
    logic        sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [1:0]  sd_ba;
    logic [11:0] sd_addr;
    logic [1:0]  sd_dqm;
    logic [15:0] sd_dq_out;
    logic        sd_dq_oe;
    logic [15:0] sd_dq_in = 16'hBAD0;

    always #10 clk = ~clk;

    sdram_ctrl #(
        .CLK_KHZ(CLK_KHZ), .HIGH_TEMP(1'b0), .INIT_CYCLES(INIT),
        .TRCD(TRCD), .TRP(TRP), .TRC(TRC), .TWR(TWR), .CAS_LAT(CL)
    ) u_sdram_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_mask(req_mask), .rd_valid(rd_valid), .rd_data(rd_data),
        .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
        .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr), .sd_dqm(sd_dqm),
        .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in)
    );

    int chk_cnt = 0;
    int fail_cnt = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        chk_cnt++;
        if (!ok) begin
            fail_cnt++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", chk_cnt, fail_cnt);
            $finish;
        end
    endtask

    // ---------------- memory and protocol model ----------------
    int          cyc;
    logic [15:0] mem [int];
    bit          open_b [4];
    logic [11:0] open_row [4];
    int          act_cyc [4];
    int          earliest = 0;
    int          drive_cyc = -100, exp_rv_cyc = -100;
    logic [15:0] pend_data;
    int          n_cmds = 0;
    logic [3:0]  init_cmd [4];
    logic [11:0] init_a [4];
    int          first_cmd_cyc = -1;
    bit          lmr_seen = 0, ready_seen = 0;
    int          last_key = -1;
    int          ref_total = 0, last_ref_cyc = -1, max_gap = 0, periodic_refs = 0;
    logic [3:0]  mc;
    int          key;
    logic [15:0] old_w;

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    always @(negedge clk) begin
        if (!rst) begin
            mc = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
            sd_dq_in = (cyc == drive_cyc) ? pend_data : 16'hBAD0;
            if (rd_valid || cyc == exp_rv_cyc)
                check(rd_valid && cyc == exp_rv_cyc, "R11 strobe timing", cyc, exp_rv_cyc);
            if (req_ready && !ready_seen) begin
                ready_seen = 1;
                check(lmr_seen, "R3 ready before mode load", 0, 1);
            end
            if (mc != C_NOP) begin
                if (n_cmds < 4) begin
                    init_cmd[n_cmds] = mc;
                    init_a[n_cmds]   = sd_addr;
                end
                if (n_cmds == 0) first_cmd_cyc = cyc;
                n_cmds++;
                case (mc)
                    C_ACT: begin
                        check(!open_b[sd_ba] && cyc >= earliest, "R6 active spacing", cyc, earliest);
                        open_b[sd_ba]   = 1;
                        open_row[sd_ba] = sd_addr;
                        act_cyc[sd_ba]  = cyc;
                    end
                    C_RD, C_WR: begin
                        check(open_b[sd_ba] && (cyc - act_cyc[sd_ba]) >= TRCD && sd_addr[10],
                              "R5 access after active", cyc - act_cyc[sd_ba], TRCD);
                        key      = int'({sd_ba, open_row[sd_ba], sd_addr[7:0]});
                        last_key = key;
                        open_b[sd_ba] = 0;
                        if (mc == C_WR) begin
                            check(sd_dq_oe, "R8 write drives data", sd_dq_oe, 1);
                            old_w = mem.exists(key) ? mem[key] : 16'h0000;
                            mem[key] = {sd_dqm[1] ? old_w[15:8] : sd_dq_out[15:8],
                                        sd_dqm[0] ? old_w[7:0]  : sd_dq_out[7:0]};
                            earliest = cyc + TWR + TRP;
                        end else begin
                            check(sd_dqm == 2'b00 && !sd_dq_oe, "R8 read masks", sd_dqm, 0);
                            pend_data  = mem.exists(key) ? mem[key] : 16'hBAD1;
                            drive_cyc  = cyc + CL;
                            exp_rv_cyc = cyc + CL + 1;
                            earliest   = cyc + CL + TRP;
                        end
                    end
                    C_REF: begin
                        check(!(open_b[0] || open_b[1] || open_b[2] || open_b[3]) && cyc >= earliest,
                              "R9 refresh with banks idle", cyc, earliest);
                        ref_total++;
                        if (ref_total > 3) begin
                            periodic_refs++;
                            if (cyc - last_ref_cyc > max_gap) max_gap = cyc - last_ref_cyc;
                        end
                        last_ref_cyc = cyc;
                        earliest = cyc + TRC;
                    end
                    C_PRE: begin
                        check(cyc >= earliest, "R6 precharge spacing", cyc, earliest);
                        if (sd_addr[10]) for (int b = 0; b < 4; b++) open_b[b] = 0;
                        else open_b[sd_ba] = 0;
                        earliest = cyc + TRP;
                    end
                    C_LMR: begin
                        lmr_seen = 1;
                        earliest = cyc + 2;
                    end
                    default: check(0, "R1 unknown command", mc, C_NOP);
                endcase
            end
        end
    end

    // ---------------- stimulus ----------------
    typedef struct packed {
        logic        wr;
        logic [21:0] addr;
        logic [15:0] data;
        logic [1:0]  mask;
        logic [15:0] exp;
    } vec_t;

    localparam vec_t VECS [13] = '{
        '{1'b1, 22'h00050A, 16'hA1B2, 2'b00, 16'h0000},
        '{1'b1, 22'h3FFFFF, 16'h55AA, 2'b00, 16'h0000},
        '{1'b1, 22'h100100, 16'h1357, 2'b00, 16'h0000},
        '{1'b0, 22'h00050A, 16'h0000, 2'b00, 16'hA1B2},
        '{1'b0, 22'h3FFFFF, 16'h0000, 2'b00, 16'h55AA},
        '{1'b1, 22'h00050A, 16'hFFEE, 2'b01, 16'h0000},
        '{1'b0, 22'h00050A, 16'h0000, 2'b00, 16'hFFB2},
        '{1'b1, 22'h100100, 16'hCCDD, 2'b10, 16'h0000},
        '{1'b0, 22'h100100, 16'h0000, 2'b00, 16'h13DD},
        '{1'b1, 22'h3FFFFF, 16'h9999, 2'b11, 16'h0000},
        '{1'b0, 22'h3FFFFF, 16'h0000, 2'b00, 16'h55AA},
        '{1'b1, 22'h200000, 16'h0F0F, 2'b00, 16'h0000},
        '{1'b0, 22'h200000, 16'h0000, 2'b00, 16'h0F0F}
    };

    task automatic do_req(input logic wr, input logic [21:0] addr, input logic [15:0] data,
                          input logic [1:0] mask, output int lat, output logic [15:0] rdat);
        req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = data; req_mask = mask;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        rdat = 16'h0000;
        if (!wr) begin
            while (!rd_valid && lat < 40) begin
                @(negedge clk);
                lat++;
            end
            rdat = rd_data;
        end else begin
            repeat (10) @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(0, "watchdog expired", 0, 1);
        report();
    end

    initial begin
        int          lat;
        logic [15:0] rdat;
        logic [21:0] a;
        logic [15:0] d;
        rst = 1'b1; req_valid = 1'b0; req_write = 1'b0;
        req_addr = '0; req_wdata = '0; req_mask = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == C_NOP, "R1 reset command",
              {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, C_NOP);
        check(!req_ready, "R1 reset ready", req_ready, 0);
        check(!rd_valid, "R1 reset strobe", rd_valid, 0);
        rst = 1'b0;

        while (!req_ready) @(negedge clk);
        // R2: power-up order and mode word
        check(init_cmd[0] == C_PRE && init_a[0][10], "R2 first is precharge-all", init_cmd[0], C_PRE);
        check(init_cmd[1] == C_REF, "R2 second is refresh", init_cmd[1], C_REF);
        check(init_cmd[2] == C_REF, "R2 third is refresh", init_cmd[2], C_REF);
        check(init_cmd[3] == C_LMR && init_a[3] == 12'h030, "R2 mode load word", init_a[3], 12'h030);
        // R3: settle time honoured
        check(first_cmd_cyc >= INIT, "R3 settle time", first_cmd_cyc, INIT);

        foreach (VECS[i]) begin
            do_req(VECS[i].wr, VECS[i].addr, VECS[i].data, VECS[i].mask, lat, rdat);
            check(last_key == int'(VECS[i].addr), "R4 address split", last_key, VECS[i].addr);
            if (!VECS[i].wr) begin
                check(lat == TRCD + CL + 2, "R7 read latency", lat, TRCD + CL + 2);
                check(rdat == VECS[i].exp, "R8 read-back with masks", rdat, VECS[i].exp);
            end
        end

        // R10: continuous stream; refreshes must still get through
        for (int i = 0; i < 24; i++) begin
            a = {2'(i), 12'(i * 37), 8'(i * 5)};
            d = 16'(i * 16'h0101) ^ 16'h5A5A;
            do_req(1'b1, a, d, 2'b00, lat, rdat);
        end
        for (int i = 0; i < 24; i++) begin
            a = {2'(i), 12'(i * 37), 8'(i * 5)};
            d = 16'(i * 16'h0101) ^ 16'h5A5A;
            do_req(1'b0, a, 16'h0000, 2'b00, lat, rdat);
            check(rdat == d && lat == TRCD + CL + 2, "R7 streamed read", rdat, d);
        end

        check(periodic_refs >= 10, "R9 refresh count", periodic_refs, 10);
        check(max_gap <= REF_PER + 12, "R10 refresh gap under load", max_gap, REF_PER + 12);
        report();
    end

endmodule